// File: doc/BRIEF.md
# Channel Service Round-Robin Scheduler

This block chooses which data channel a transfer sequencer serves next. Each channel moves items between a coprocessor and a software channel held in memory, and each has a local hardware FIFO. There are two directions with their own parameterized counts. A channel toward the coprocessor asks for service when its FIFO runs empty, so it needs a refill. A channel from the coprocessor asks for service when its FIFO fills up, so it needs a drain. A channel can only ask while its running bit is set.

All channels form one ordered list: first the toward-coprocessor channels in index order, then the from-coprocessor channels. A pointer into this list sets where the round-robin search starts. Each channel also has a revisit timer, which keeps the channel out of the search for a fixed number of cycles after its last service ends.

The grant acts as a valid-only stream toward the sequencer. `grant_valid` is held with a stable channel and direction until `seq_done` is seen. That pulse is the sequencer's back-pressure: it stands for the whole five-step bus sequence, so the grant stays up for however long the sequence takes. A `seq_done` while no grant is up is ignored. A new grant can appear no earlier than the cycle after the edge that accepts `seq_done`. `flush` and `rst_n` clear everything.

Top module: `rr_chan_sched`

## Requirements
- R1: After reset `grant_valid` is 0 and the pointer is at list position 0. The first grant goes to the lowest list position that requests.
- R2: Toward-coprocessor channel i requests when `to_empty[i]` and `run_to[i]` are both 1. It is list position i.
- R3: From-coprocessor channel j requests when `from_full[j]` and `run_from[j]` are both 1. It is list position N_TO+j.
- R4: A channel whose running bit is 0 is never granted, whatever its FIFO flags show.
- R5: While idle, the grant goes to the first eligible position found from the pointer upward, wrapping around. After a grant at position g the pointer becomes g+1 (mod N_TO+N_FROM).
- R6: The edge that accepts `seq_done` for position g loads its timer with REVISIT. The timer counts down once per cycle. g is eligible only while its timer is 0, so its next grant rises at least REVISIT+1 edges after that edge.
- R7: A grant holds its channel and direction until a clock edge samples `seq_done`=1. At that edge the grant drops. `seq_done` with no grant has no effect.
- R8: At most one grant is up at a time. `grant_dir` is 0 for toward-coprocessor and 1 for from-coprocessor. `grant_chan` is below that direction's channel count.
- R9: `flush`=1 at an edge clears the grant, the pointer and all revisit timers, exactly as reset does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Controller flush, same effect as reset |
| to_empty | input | N_TO | FIFO empty flags, toward-coprocessor channels |
| from_full | input | N_FROM | FIFO full flags, from-coprocessor channels |
| run_to | input | N_TO | Running bits, toward-coprocessor channels |
| run_from | input | N_FROM | Running bits, from-coprocessor channels |
| seq_done | input | 1 | Sequencer finished the granted service |
| grant_valid | output | 1 | A grant is outstanding |
| grant_dir | output | 1 | 0 toward coprocessor, 1 from coprocessor |
| grant_chan | output | CW | Channel index within its direction |

## Verification
The bench compares the grant outputs on every cycle against a behavioural model of the pointer, the timers and the grant, so most state errors show up at the next grant. A pointer that lands in the wrong place shows as a wrong `grant_chan` or `grant_dir` on the next grant when several channels request at once. A revisit timer that loads or counts wrongly shows as a grant that comes too early or too late for a channel that requests without pause. A grant register that releases early or holds too long shows as a `grant_valid` mismatch within one cycle of `seq_done`.

// File: rtl/rr_sched_pkg.sv
package rr_sched_pkg;
  typedef enum logic {
    DIR_TO   = 1'b0,
    DIR_FROM = 1'b1
  } chan_dir_e;

  function automatic int unsigned width_of(input int unsigned count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/rr_req_map.sv
module rr_req_map #(
  parameter int N_TO   = 3,
  parameter int N_FROM = 2,
  localparam int N     = N_TO + N_FROM
) (
  input  logic [N_TO-1:0]   to_empty,
  input  logic [N_FROM-1:0] from_full,
  input  logic [N_TO-1:0]   run_to,
  input  logic [N_FROM-1:0] run_from,
  output logic [N-1:0]      req
);
  // List order: toward-coprocessor channels first, then from-coprocessor
  for (genvar i = 0; i < N_TO; i++) begin : g_to
    assign req[i] = to_empty[i] & run_to[i];
  end
  for (genvar j = 0; j < N_FROM; j++) begin : g_from
    assign req[N_TO+j] = from_full[j] & run_from[j];
  end
endmodule

// File: rtl/rr_revisit_timers.sv
module rr_revisit_timers #(
  parameter int N       = 5,
  parameter int REVISIT = 6,
  parameter int LW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          load,
  input  logic [LW-1:0] load_idx,
  output logic [N-1:0]  ready
);
  localparam int TW = rr_sched_pkg::width_of(REVISIT + 1);

  if (REVISIT == 0) begin : g_none
    assign ready = '1;
  end else begin : g_cnt
    for (genvar i = 0; i < N; i++) begin : g_ch
      logic [TW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n || flush)
          cnt <= '0;
        else if (load && load_idx == LW'(i))
          cnt <= TW'(REVISIT);
        else if (cnt != '0)
          cnt <= cnt - 1'b1;
      end
      assign ready[i] = (cnt == '0);
    end
  end
endmodule

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N  = 5,
  parameter int LW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [LW-1:0] ptr,
  output logic          found,
  output logic [LW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      int pos;
      logic [LW-1:0] pos_l;
      pos = int'(ptr) + k;
      if (pos >= N) pos = pos - N;
      pos_l = LW'(pos);
      if (!found && req[pos_l]) begin
        found = 1'b1;
        idx   = pos_l;
      end
    end
  end
endmodule

// File: rtl/rr_chan_sched.sv
module rr_chan_sched #(
  parameter int N_TO    = 3,
  parameter int N_FROM  = 2,
  parameter int REVISIT = 6,
  localparam int N      = N_TO + N_FROM,
  localparam int LW     = rr_sched_pkg::width_of(N),
  localparam int CW     = rr_sched_pkg::width_of((N_TO > N_FROM) ? N_TO : N_FROM)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [N_TO-1:0]   to_empty,
  input  logic [N_FROM-1:0] from_full,
  input  logic [N_TO-1:0]   run_to,
  input  logic [N_FROM-1:0] run_from,
  input  logic              seq_done,
  output logic              grant_valid,
  output logic              grant_dir,
  output logic [CW-1:0]     grant_chan
);
  import rr_sched_pkg::*;

  logic [N-1:0]  req, ready, eligible;
  logic [LW-1:0] ptr, pick, gidx;
  logic          found, gv, release_now;
  chan_dir_e     dir;

  rr_req_map #(.N_TO(N_TO), .N_FROM(N_FROM)) u_map (
    .to_empty(to_empty), .from_full(from_full),
    .run_to(run_to), .run_from(run_from), .req(req)
  );

  assign release_now = gv & seq_done & ~flush;

  rr_revisit_timers #(.N(N), .REVISIT(REVISIT), .LW(LW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .load(release_now), .load_idx(gidx), .ready(ready)
  );

  assign eligible = req & ready;

  rr_pick #(.N(N), .LW(LW)) u_pick (
    .req(eligible), .ptr(ptr), .found(found), .idx(pick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      gv   <= 1'b0;
      gidx <= '0;
      ptr  <= '0;
    end else if (gv) begin
      if (seq_done) gv <= 1'b0;
    end else if (found) begin
      gv   <= 1'b1;
      gidx <= pick;
      ptr  <= (pick == LW'(N - 1)) ? '0 : pick + 1'b1;
    end
  end

  always_comb begin
    dir = (gidx >= LW'(N_TO)) ? DIR_FROM : DIR_TO;
    if (dir == DIR_FROM) grant_chan = CW'(gidx - LW'(N_TO));
    else                 grant_chan = CW'(gidx);
  end

  assign grant_valid = gv;
  assign grant_dir   = dir;
endmodule

// File: rtl/rr_chan_sched_chk.sv
module rr_chan_sched_chk #(
  parameter int N_TO   = 3,
  parameter int N_FROM = 2,
  localparam int N     = N_TO + N_FROM,
  localparam int LW    = rr_sched_pkg::width_of(N),
  localparam int CW    = rr_sched_pkg::width_of((N_TO > N_FROM) ? N_TO : N_FROM)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic [N_TO-1:0]   to_empty,
  input logic [N_FROM-1:0] from_full,
  input logic [N_TO-1:0]   run_to,
  input logic [N_FROM-1:0] run_from,
  input logic              seq_done,
  input logic              grant_valid,
  input logic              grant_dir,
  input logic [CW-1:0]     grant_chan
);
  logic [N-1:0]  req_now, req_q;
  logic [LW-1:0] lidx;

  assign req_now = {from_full & run_from, to_empty & run_to};
  assign lidx = grant_dir ? (LW'(grant_chan) + LW'(N_TO)) : LW'(grant_chan);

  always_ff @(posedge clk) req_q <= req_now;

  // R7
  hold_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !seq_done && !flush) |=>
      (grant_valid && $stable(grant_chan) && $stable(grant_dir)));

  // R7
  release_on_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && seq_done) |=> !grant_valid);

  // R4
  grant_was_requested_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(grant_valid) |-> req_q[lidx]);

  // R8
  chan_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_valid |-> (grant_dir ? (int'(grant_chan) < N_FROM) : (int'(grant_chan) < N_TO)));

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !grant_valid);
endmodule

bind rr_chan_sched rr_chan_sched_chk #(.N_TO(N_TO), .N_FROM(N_FROM)) u_chk (.*);

// File: tb/sim_rr_chan_sched.sv
module sim_rr_chan_sched;
  localparam int NT = 3;
  localparam int NF = 2;
  localparam int RV = 6;
  localparam int N  = NT + NF;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic [NT-1:0] to_empty = '0, run_to = '0;
  logic [NF-1:0] from_full = '0, run_from = '0;
  logic seq_done = 1'b0;
  logic grant_valid, grant_dir;
  logic [CW-1:0] grant_chan;

  always #5 clk = ~clk;

  rr_chan_sched #(.N_TO(NT), .N_FROM(NF), .REVISIT(RV)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .to_empty(to_empty),
    .from_full(from_full), .run_to(run_to), .run_from(run_from),
    .seq_done(seq_done), .grant_valid(grant_valid),
    .grant_dir(grant_dir), .grant_chan(grant_chan)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  // reference state
  int m_ptr = 0, m_gv = 0, m_g = 0;
  int m_tmr [N];
  int last_done_cyc [N];
  int cyc = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  function automatic bit m_req(int i);
    if (i < NT) return to_empty[i] && run_to[i];
    return from_full[i-NT] && run_from[i-NT];
  endfunction

  // advance the model across the coming clock edge, using the inputs now driven
  task automatic model_step();
    int nt [N];
    for (int i = 0; i < N; i++) nt[i] = (m_tmr[i] > 0) ? m_tmr[i] - 1 : 0;
    if (!rst_n || flush) begin
      m_gv = 0; m_g = 0; m_ptr = 0;
      for (int i = 0; i < N; i++) nt[i] = 0;
    end else if (m_gv != 0) begin
      if (seq_done) begin
        nt[m_g] = RV; m_gv = 0; last_done_cyc[m_g] = cyc;
      end
    end else begin
      for (int k = 0; k < N; k++) begin
        int p = (m_ptr + k) % N;
        if (m_gv == 0 && m_req(p) && m_tmr[p] == 0) begin
          m_gv = 1; m_g = p; m_ptr = (p + 1) % N;
        end
      end
    end
    for (int i = 0; i < N; i++) m_tmr[i] = nt[i];
  endtask

  task automatic compare(string tag);
    check(tag, int'(grant_valid), m_gv);
    if (m_gv != 0) begin
      check(tag, int'(grant_dir), (m_g >= NT) ? 1 : 0);
      check(tag, int'(grant_chan), (m_g >= NT) ? m_g - NT : m_g);
    end
  endtask

  // one cycle: compare at negedge, drive, predict
  task automatic cyc_run(string tag, int p_flag, int p_run, int p_done, int p_idle, int p_flush);
    @(negedge clk);
    compare(tag);
    cyc++;
    for (int i = 0; i < NT; i++) begin
      to_empty[i] = ($urandom % 100) < p_flag;
      run_to[i]   = ($urandom % 100) < p_run;
    end
    for (int j = 0; j < NF; j++) begin
      from_full[j] = ($urandom % 100) < p_flag;
      run_from[j]  = ($urandom % 100) < p_run;
    end
    seq_done = ($urandom % 100) < ((m_gv != 0) ? p_done : p_idle);
    flush    = ($urandom % 100) < p_flush;
    model_step();
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin m_tmr[i] = 0; last_done_cyc[i] = -1000; end
    // R1: reset state
    for (int n = 0; n < 4; n++) begin
      @(negedge clk); compare("R1"); cyc++; model_step();
    end
    rst_n = 1'b1;
    // R1: all request at once, first grant is position 0
    to_empty = '1; run_to = '1; from_full = '1; run_from = '1;
    model_step();
    @(negedge clk); cyc++;
    check("R1", int'(grant_valid), 1);
    check("R1", int'(grant_dir), 0);
    check("R1", int'(grant_chan), 0);
    compare("R1");
    seq_done = 1'b1; model_step();
    for (int n = 0; n < 300; n++) cyc_run("R2", 50, 100, 30, 0, 0) ;
    // R2: toward only
    for (int n = 0; n < 300; n++) begin
      cyc_run("R2", 50, 100, 30, 0, 0);
      from_full = '0; model_fix();
    end
    // R3: from only
    for (int n = 0; n < 300; n++) begin
      cyc_run("R3", 50, 100, 30, 0, 0);
      to_empty = '0; model_fix();
    end
    for (int n = 0; n < 300; n++) cyc_run("R4", 100, 30, 40, 0, 0);
    for (int n = 0; n < 300; n++) cyc_run("R5", 100, 100, 60, 0, 0);
    // R6: one channel requesting continuously, done at once
    for (int n = 0; n < 300; n++) begin
      cyc_run("R6", 0, 100, 100, 0, 0);
      to_empty = 3'b010; model_fix();
    end
    for (int n = 0; n < 300; n++) cyc_run("R7", 60, 80, 5, 50, 0);
    for (int n = 0; n < 300; n++) cyc_run("R9", 60, 80, 30, 10, 8);
    for (int n = 0; n < 600; n++) cyc_run("R8", 50, 70, 35, 20, 2);
    @(negedge clk); compare("R8");
    finish_run();
  end

  // after overriding inputs within a cycle, redo the prediction from the saved state
  int s_ptr, s_gv, s_g;
  int s_tmr [N];
  always @(posedge clk) begin
    s_ptr <= m_ptr; s_gv <= m_gv; s_g <= m_g;
    for (int i = 0; i < N; i++) s_tmr[i] <= m_tmr[i];
  end

  task automatic model_fix();
    // restore pre-edge state (values before this cycle's prediction) and predict again
    m_ptr = s_ptr_pre; m_gv = s_gv_pre; m_g = s_g_pre;
    for (int i = 0; i < N; i++) m_tmr[i] = s_tmr_pre[i];
    if (seq_done && m_gv == 0) seq_done = 1'b0;
    model_step();
  endtask

  // state as seen at the last negedge, before prediction
  int s_ptr_pre, s_gv_pre, s_g_pre;
  int s_tmr_pre [N];
  always @(negedge clk) begin
    s_ptr_pre = m_ptr; s_gv_pre = m_gv; s_g_pre = m_g;
    for (int i = 0; i < N; i++) s_tmr_pre[i] = m_tmr[i];
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    checks++; fails++;
    $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
    finish_run();
  end
endmodule